// File: doc/BRIEF.md
# Signal Sequence Concatenator with Boundary Merge

The block plays back a chain of pre-registered waveform fragments as a single stream of period durations for a downstream pin generator. Each fragment (a "signal") lives in a 32-slot bank and is described by its starting level, a count of period entries, a base pointer into a shared period memory, and a signed fractional remainder. Software-side logic fills the bank and the period memory through plain write strobes, pushes signal indices into an ordered play list, and pulses a start strobe. The walker then reads the list, fetches each descriptor and its periods through synchronous reads, and produces durations in order.

Two fragments that meet at the same level would cause a redundant edge. The walker therefore folds the last period of the first fragment into the first period of the second. Fractional timing error from each fragment is gathered in a signed accumulator, and one tick is added whenever half a tick unit has built up. The very last period of the whole chain is never sent, so the pin generator holds that final level. Before any duration, the first fragment's start level is presented once on a strobe so the pin generator can preset the pin.

Durations leave on a valid/ready stream. Once `o_dur_valid` is raised, it stays high and `o_dur_data`/`o_dur_last` hold steady until a cycle with `i_dur_ready` high completes the transfer. The sink may hold `i_dur_ready` low for any number of cycles, and the walker stalls without losing or reordering items. `o_dur_last` marks the final duration sent in a walk.

Top module: `seqcat_top`

## Requirements
- R1: A descriptor write with an index of 32 or more, or with a period count of 0, is rejected (`o_reject` high in the next cycle) and leaves every bank entry unchanged. A list push with an index of 32 or more is rejected and does not lengthen the list.
- R2: A start pulse while the list is empty is rejected, and `o_busy` stays low.
- R3: After an accepted start, `o_init_strobe` pulses exactly once, carrying the first listed signal's start level on `o_init_level`, before any duration is transferred.
- R4: Periods are emitted in list order and, within a signal, in entry order from its base address upward. Each emitted value is the stored period plus any pending carry, and the carry is then cleared.
- R5: A signal's end level is its start level XOR (period count is even). When it matches the next listed signal's start level, its last period is withheld and added to that next signal's first period.
- R6: When a signal's end level differs from the next signal's start level, its last period is emitted by itself.
- R7: The last period of the last listed signal is never emitted. A walk whose only signal has one period emits no duration.
- R8: After every signal except the last, its remainder (two's complement, 16 bits) is added to a signed accumulator that starts at zero. If the sum is at least TICK_UNIT>>1, TICK_UNIT is subtracted and one tick is added to the next emitted period.
- R9: `o_dur_last` is high on the final emitted duration of a walk and low on every other one.
- R10: While `o_dur_valid` is high and `i_dur_ready` is low, the valid, data and last outputs hold their values in the next cycle.
- R11: `o_busy` rises in the cycle after an accepted start and falls only after the final duration has been accepted. While busy, a start pulse and a list push are rejected, and the walk in progress is not disturbed.
- R12: `i_list_clear` (when idle) empties the play list, so that a later start is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| i_desc_we | input | 1 | Write strobe for a bank descriptor |
| i_desc_idx | input | 6 | Bank slot to write (32 and up rejected) |
| i_desc_level | input | 1 | Start level of the signal |
| i_desc_base | input | 8 | First period address in period memory |
| i_desc_count | input | 8 | Number of period entries (1 to 255) |
| i_desc_rem | input | 16 | Signed fractional remainder |
| i_per_we | input | 1 | Period memory write strobe |
| i_per_addr | input | 8 | Period memory address |
| i_per_data | input | 32 | Period duration in ticks |
| i_list_push | input | 1 | Append an index to the play list |
| i_list_idx | input | 6 | Index to append (32 and up rejected) |
| i_list_clear | input | 1 | Empty the play list |
| i_start | input | 1 | Begin a walk of the play list |
| o_busy | output | 1 | Walk in progress |
| o_reject | output | 1 | Previous cycle's command was refused |
| o_init_level | output | 1 | Initial pin level for the walk |
| o_init_strobe | output | 1 | One-cycle pulse qualifying `o_init_level` |
| o_dur_valid | output | 1 | Duration stream valid |
| i_dur_ready | input | 1 | Duration stream ready |
| o_dur_data | output | 32 | Duration in ticks |
| o_dur_last | output | 1 | Final duration of the walk |

## Verification
The boundary merge and the rounding correction both write the same carry, and they can do so for the same boundary. The merged period is loaded into the carry first, and then the accumulator crossing half a unit adds one more tick to it. A four-entry play list alternates a non-merging fragment with a merging one whose remainders push the accumulator past the threshold at exactly the merging boundary. The scoreboard expects the next fragment's first period to equal stored value, plus the withheld period, plus one. A pseudo-random ready pattern is applied during that walk, so the flush of the final item (with its last flag) meets a stalled sink as well.

// File: rtl/seqcat_pkg.sv
package seqcat_pkg;
  parameter int BANK_N = 32;
  parameter int BA_W   = $clog2(BANK_N);
  parameter int IDX_W  = BA_W + 1;
  parameter int LIST_N = 16;
  parameter int LPOS_W = $clog2(LIST_N);
  parameter int LLEN_W = LPOS_W + 1;
  parameter int PER_N  = 256;
  parameter int PA_W   = $clog2(PER_N);
  parameter int CNT_W  = 8;
  parameter int REM_W  = 16;
  parameter int DUR_W  = 32;
  parameter int ACC_W  = 32;

  typedef struct packed {
    logic                    lvl;
    logic [PA_W-1:0]         base;
    logic [CNT_W-1:0]        cnt;
    logic signed [REM_W-1:0] rem;
  } sig_desc_t;

  typedef enum logic [3:0] {
    W_IDLE, W_DESC, W_DESC_W, W_NEXT_W, W_PER, W_PER_W,
    W_PUSH, W_ADV, W_FLUSH, W_DRAIN
  } walk_st_t;
endpackage

// File: rtl/seqcat_desc_bank.sv
module seqcat_desc_bank
  import seqcat_pkg::*;
#(
  parameter int DEPTH = BANK_N,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic      clk,
  input  logic      we,
  input  logic [AW-1:0] waddr,
  input  sig_desc_t wdata,
  input  logic [AW-1:0] raddr,
  output sig_desc_t rdata
);
  sig_desc_t slots [DEPTH];

  always_ff @(posedge clk) begin
    if (we) slots[waddr] <= wdata;
    rdata <= slots[raddr];
  end
endmodule

// File: rtl/seqcat_period_mem.sv
module seqcat_period_mem
  import seqcat_pkg::*;
#(
  parameter int DEPTH = PER_N,
  parameter int W     = DUR_W,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/seqcat_walker.sv
module seqcat_walker
  import seqcat_pkg::*;
#(
  parameter int TICK_UNIT = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LLEN_W-1:0] list_len,
  output logic [LPOS_W-1:0] lst_addr,
  input  logic [IDX_W-1:0]  lst_idx,
  output logic [BA_W-1:0]   desc_raddr,
  input  sig_desc_t         desc_rdata,
  output logic [PA_W-1:0]   per_raddr,
  input  logic [DUR_W-1:0]  per_rdata,
  output logic              busy,
  output logic              init_level,
  output logic              init_strobe,
  output logic              dur_valid,
  input  logic              dur_ready,
  output logic [DUR_W-1:0]  dur_data,
  output logic              dur_last
);
  localparam logic signed [ACC_W-1:0] HALF_S = ACC_W'(TICK_UNIT >> 1);
  localparam logic signed [ACC_W-1:0] TICK_S = ACC_W'(TICK_UNIT);

  walk_st_t                st;
  logic [LLEN_W-1:0]       pos;
  logic [CNT_W-1:0]        pi;
  sig_desc_t               cur;
  logic                    nxt_lvl, has_nxt;
  logic [DUR_W-1:0]        carry, cand, pend;
  logic                    pend_v;
  logic signed [ACC_W-1:0] acc;

  logic [LLEN_W-1:0]       pos_p1;
  logic                    lastp, end_lvl, merge, hold, slot_free;
  logic [DUR_W-1:0]        val;
  logic signed [ACC_W-1:0] acc_n;

  assign pos_p1     = pos + LLEN_W'(1);
  assign lst_addr   = (st == W_DESC_W) ? pos_p1[LPOS_W-1:0] : pos[LPOS_W-1:0];
  assign desc_raddr = lst_idx[BA_W-1:0];
  assign per_raddr  = cur.base + PA_W'(pi);
  assign busy       = (st != W_IDLE);

  assign lastp     = (pi == cur.cnt - CNT_W'(1));
  assign end_lvl   = cur.lvl ^ ~cur.cnt[0];
  assign merge     = lastp && has_nxt && (end_lvl == nxt_lvl);
  assign hold      = lastp && !has_nxt;
  assign val       = per_rdata + carry;
  assign acc_n     = acc + {{(ACC_W-REM_W){cur.rem[REM_W-1]}}, cur.rem};
  assign slot_free = !dur_valid || dur_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= W_IDLE; pos <= '0; pi <= '0; cur <= '0;
      nxt_lvl <= 1'b0; has_nxt <= 1'b0;
      carry <= '0; cand <= '0; pend <= '0; pend_v <= 1'b0; acc <= '0;
      init_level <= 1'b0; init_strobe <= 1'b0;
      dur_valid <= 1'b0; dur_data <= '0; dur_last <= 1'b0;
    end else begin
      init_strobe <= 1'b0;
      if (dur_valid && dur_ready) dur_valid <= 1'b0;
      case (st)
        W_IDLE: if (start) begin
          pos <= '0; pi <= '0; carry <= '0; acc <= '0; pend_v <= 1'b0;
          st <= W_DESC;
        end
        W_DESC: st <= W_DESC_W;
        W_DESC_W: begin
          cur <= desc_rdata;
          if (pos == '0) begin
            init_level  <= desc_rdata.lvl;
            init_strobe <= 1'b1;
          end
          if (pos_p1 < list_len) st <= W_NEXT_W;
          else begin has_nxt <= 1'b0; st <= W_PER; end
        end
        W_NEXT_W: begin
          nxt_lvl <= desc_rdata.lvl;
          has_nxt <= 1'b1;
          st      <= W_PER;
        end
        W_PER: st <= W_PER_W;
        W_PER_W: begin
          carry <= merge ? val : '0;
          cand  <= val;
          st    <= (merge || hold) ? W_ADV : W_PUSH;
        end
        W_PUSH: begin
          if (!pend_v) begin
            pend <= cand; pend_v <= 1'b1; st <= W_ADV;
          end else if (slot_free) begin
            dur_valid <= 1'b1; dur_data <= pend; dur_last <= 1'b0;
            pend <= cand; st <= W_ADV;
          end
        end
        W_ADV: begin
          if (!lastp) begin
            pi <= pi + CNT_W'(1); st <= W_PER;
          end else if (has_nxt) begin
            if (acc_n >= HALF_S) begin
              acc   <= acc_n - TICK_S;
              carry <= carry + DUR_W'(1);
            end else acc <= acc_n;
            pos <= pos_p1; pi <= '0; st <= W_DESC;
          end else st <= W_FLUSH;
        end
        W_FLUSH: begin
          if (!pend_v) st <= W_DRAIN;
          else if (slot_free) begin
            dur_valid <= 1'b1; dur_data <= pend; dur_last <= 1'b1;
            pend_v <= 1'b0; st <= W_DRAIN;
          end
        end
        W_DRAIN: if (!dur_valid) st <= W_IDLE;
        default: st <= W_IDLE;
      endcase
    end
  end

  a_r10_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    dur_valid && !dur_ready |=> dur_valid && $stable(dur_data) && $stable(dur_last));

  a_r9_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
    dur_valid && dur_ready && dur_last |=> !dur_valid);

  a_r3_init_before_data: assert property (@(posedge clk) disable iff (!rst_n)
    init_strobe |-> !dur_valid && !pend_v);

  a_r11_busy_covers_out: assert property (@(posedge clk) disable iff (!rst_n)
    dur_valid |-> busy);
endmodule

// File: rtl/seqcat_top.sv
module seqcat_top
  import seqcat_pkg::*;
#(
  parameter int TICK_UNIT = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_desc_we,
  input  logic [IDX_W-1:0]  i_desc_idx,
  input  logic              i_desc_level,
  input  logic [PA_W-1:0]   i_desc_base,
  input  logic [CNT_W-1:0]  i_desc_count,
  input  logic [REM_W-1:0]  i_desc_rem,
  input  logic              i_per_we,
  input  logic [PA_W-1:0]   i_per_addr,
  input  logic [DUR_W-1:0]  i_per_data,
  input  logic              i_list_push,
  input  logic [IDX_W-1:0]  i_list_idx,
  input  logic              i_list_clear,
  input  logic              i_start,
  output logic              o_busy,
  output logic              o_reject,
  output logic              o_init_level,
  output logic              o_init_strobe,
  output logic              o_dur_valid,
  input  logic              i_dur_ready,
  output logic [DUR_W-1:0]  o_dur_data,
  output logic              o_dur_last
);
  logic [IDX_W-1:0]  lst_mem [LIST_N];
  logic [LLEN_W-1:0] lst_len;
  logic [LPOS_W-1:0] lst_addr;
  logic [BA_W-1:0]   desc_raddr;
  logic [PA_W-1:0]   per_raddr;
  logic [DUR_W-1:0]  per_rdata;
  sig_desc_t         desc_rdata, desc_wdata;

  logic desc_bad, desc_ok, push_bad, push_ok, clr_bad, start_bad, start_ok;

  assign desc_bad  = i_desc_we && ((i_desc_idx >= IDX_W'(BANK_N)) || (i_desc_count == '0));
  assign desc_ok   = i_desc_we && !desc_bad;
  assign push_bad  = i_list_push && (o_busy || (i_list_idx >= IDX_W'(BANK_N)) ||
                                     (lst_len == LLEN_W'(LIST_N)));
  assign push_ok   = i_list_push && !push_bad;
  assign clr_bad   = i_list_clear && o_busy;
  assign start_bad = i_start && (o_busy || (lst_len == '0));
  assign start_ok  = i_start && !start_bad;

  assign desc_wdata = '{lvl: i_desc_level, base: i_desc_base,
                        cnt: i_desc_count, rem: $signed(i_desc_rem)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lst_len  <= '0;
      o_reject <= 1'b0;
    end else begin
      o_reject <= desc_bad || push_bad || clr_bad || start_bad;
      if (i_list_clear && !o_busy) lst_len <= '0;
      else if (push_ok)            lst_len <= lst_len + LLEN_W'(1);
    end
  end

  for (genvar g = 0; g < LIST_N; g++) begin : g_list
    always_ff @(posedge clk) begin
      if (push_ok && !i_list_clear && (lst_len == LLEN_W'(g))) lst_mem[g] <= i_list_idx;
    end
  end

  seqcat_desc_bank #(.DEPTH(BANK_N)) u_bank (
    .clk(clk), .we(desc_ok), .waddr(i_desc_idx[BA_W-1:0]), .wdata(desc_wdata),
    .raddr(desc_raddr), .rdata(desc_rdata));

  seqcat_period_mem #(.DEPTH(PER_N), .W(DUR_W)) u_pmem (
    .clk(clk), .we(i_per_we), .waddr(i_per_addr), .wdata(i_per_data),
    .raddr(per_raddr), .rdata(per_rdata));

  seqcat_walker #(.TICK_UNIT(TICK_UNIT)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start_ok), .list_len(lst_len),
    .lst_addr(lst_addr), .lst_idx(lst_mem[lst_addr]),
    .desc_raddr(desc_raddr), .desc_rdata(desc_rdata),
    .per_raddr(per_raddr), .per_rdata(per_rdata),
    .busy(o_busy), .init_level(o_init_level), .init_strobe(o_init_strobe),
    .dur_valid(o_dur_valid), .dur_ready(i_dur_ready),
    .dur_data(o_dur_data), .dur_last(o_dur_last));

  a_r1_bad_desc: assert property (@(posedge clk) disable iff (!rst_n)
    i_desc_we && (i_desc_idx >= IDX_W'(BANK_N)) |=> o_reject);

  a_r2_empty_start: assert property (@(posedge clk) disable iff (!rst_n)
    i_start && !o_busy && (lst_len == '0) |=> !o_busy && o_reject);

  a_r11_push_busy: assert property (@(posedge clk) disable iff (!rst_n)
    i_list_push && o_busy |=> o_reject && $stable(lst_len));

  a_r11_start_rises: assert property (@(posedge clk) disable iff (!rst_n)
    i_start && !o_busy && (lst_len != '0) |=> o_busy);
endmodule

// File: tb/sim_seqcat_top.sv
`timescale 1ns/1ps
module sim_seqcat_top;
  import seqcat_pkg::*;
  localparam int TICK = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              i_desc_we = 0, i_desc_level = 0, i_per_we = 0;
  logic [IDX_W-1:0]  i_desc_idx = '0, i_list_idx = '0;
  logic [PA_W-1:0]   i_desc_base = '0, i_per_addr = '0;
  logic [CNT_W-1:0]  i_desc_count = '0;
  logic [REM_W-1:0]  i_desc_rem = '0;
  logic [DUR_W-1:0]  i_per_data = '0;
  logic              i_list_push = 0, i_list_clear = 0, i_start = 0;
  logic              i_dur_ready = 0;
  logic              o_busy, o_reject, o_init_level, o_init_strobe;
  logic              o_dur_valid, o_dur_last;
  logic [DUR_W-1:0]  o_dur_data;

  seqcat_top #(.TICK_UNIT(TICK)) u0 (.*);

  int vecs = 0, errs = 0;
  int exp_d[$];
  bit exp_l[$];
  bit exp_init;
  bit init_seen;
  int walk_xfers;
  bit bp_on = 0;
  logic [7:0] lfsr = 8'hA5;

  bit b_lvl [BANK_N];
  int b_base[BANK_N], b_cnt[BANK_N], b_rem[BANK_N];
  int b_per [PER_N];
  int lst[$];

  task automatic chk(bit ok, string tag, longint act, longint exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic nr;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    nr = bp_on ? lfsr[0] : 1'b1;
    if (rst_n && o_init_strobe) begin
      init_seen = 1;
      chk(o_init_level == exp_init, "R3 init level", o_init_level, exp_init);
      chk(walk_xfers == 0, "R3 init before data", walk_xfers, 0);
    end
    if (rst_n && o_dur_valid && nr) begin
      walk_xfers++;
      if (exp_d.size() == 0) chk(0, "R7 unexpected duration", o_dur_data, -1);
      else begin
        int ed; bit el;
        ed = exp_d.pop_front(); el = exp_l.pop_front();
        chk(o_dur_data == DUR_W'(ed), "R4 R5 R6 R8 duration", o_dur_data, ed);
        chk(o_dur_last == el, "R9 last flag", o_dur_last, el);
      end
    end
    i_dur_ready = nr;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errs++; vecs++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  task automatic reg_sig(int idx, bit lvl, int base, int cnt, int rem, bit exp_rej, string tag);
    @(negedge clk);
    i_desc_we = 1; i_desc_idx = IDX_W'(idx); i_desc_level = lvl;
    i_desc_base = PA_W'(base); i_desc_count = CNT_W'(cnt); i_desc_rem = REM_W'(rem);
    @(negedge clk);
    i_desc_we = 0;
    chk(o_reject == exp_rej, tag, o_reject, exp_rej);
    if (!exp_rej) begin
      b_lvl[idx] = lvl; b_base[idx] = base; b_cnt[idx] = cnt; b_rem[idx] = rem;
    end
  endtask

  task automatic wper(int a, int d);
    @(negedge clk);
    i_per_we = 1; i_per_addr = PA_W'(a); i_per_data = DUR_W'(d); b_per[a] = d;
    @(negedge clk);
    i_per_we = 0;
  endtask

  task automatic push(int idx, bit exp_rej, string tag);
    @(negedge clk);
    i_list_push = 1; i_list_idx = IDX_W'(idx);
    @(negedge clk);
    i_list_push = 0;
    chk(o_reject == exp_rej, tag, o_reject, exp_rej);
    if (!exp_rej) lst.push_back(idx);
  endtask

  task automatic clear_list();
    @(negedge clk);
    i_list_clear = 1;
    @(negedge clk);
    i_list_clear = 0;
    lst.delete();
  endtask

  task automatic build_expect();
    int carry = 0, acc = 0;
    int items[$];
    for (int s = 0; s < lst.size(); s++) begin
      int id = lst[s];
      bit has_next = (s + 1 < lst.size());
      for (int i = 0; i < b_cnt[id]; i++) begin
        int v = b_per[(b_base[id] + i) % PER_N] + carry;
        bit emit = 1;
        carry = 0;
        if (i == b_cnt[id] - 1) begin
          if (has_next) begin
            bit endl = b_lvl[id] ^ (b_cnt[id] % 2 == 0);
            if (endl == b_lvl[lst[s+1]]) begin carry = v; emit = 0; end
          end else emit = 0;
        end
        if (emit) items.push_back(v);
      end
      if (has_next) begin
        acc += b_rem[id];
        if (acc >= (TICK >> 1)) begin acc -= TICK; carry += 1; end
      end
    end
    for (int k = 0; k < items.size(); k++) begin
      exp_d.push_back(items[k]);
      exp_l.push_back(k == items.size() - 1);
    end
    exp_init = b_lvl[lst[0]];
  endtask

  task automatic start_walk(bit exp_rej, string tag);
    if (!exp_rej) begin
      build_expect();
      init_seen = 0; walk_xfers = 0;
    end
    @(negedge clk);
    i_start = 1;
    @(negedge clk);
    i_start = 0;
    chk(o_reject == exp_rej, tag, o_reject, exp_rej);
    chk(o_busy == !exp_rej, "R11 busy after start", o_busy, !exp_rej);
  endtask

  task automatic wait_idle(string tag);
    int n = 0;
    while ((o_busy || exp_d.size() != 0) && n < 5000) begin @(negedge clk); n++; end
    chk(!o_busy, "R11 busy falls", o_busy, 0);
    chk(exp_d.size() == 0, tag, exp_d.size(), 0);
    chk(init_seen, "R3 init strobe seen", init_seen, 1);
    repeat (3) @(negedge clk);
    chk(!o_dur_valid, "R7 nothing after walk", o_dur_valid, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(!o_busy && !o_dur_valid && !o_reject && !o_init_strobe, "reset state",
        {o_busy, o_dur_valid, o_reject, o_init_strobe}, 0);
    rst_n = 1;
    @(negedge clk);

    // periods
    wper(0, 10); wper(1, 20); wper(2, 30);
    wper(3, 5);  wper(4, 6);
    wper(10, 100); wper(11, 200);
    wper(20, 7); wper(21, 8); wper(22, 9);
    wper(30, 55); wper(40, 77);

    // R1 and R2 rejections
    reg_sig(0, 1, 0, 3, 0, 0, "R1 good desc");
    reg_sig(0, 0, 30, 0, 0, 1, "R1 count zero rejected");
    reg_sig(1, 1, 3, 2, 0, 0, "R1 good desc");
    reg_sig(8, 0, 40, 1, 0, 0, "R1 good desc");
    reg_sig(40, 1, 30, 1, 0, 1, "R1 index 40 rejected");
    start_walk(1, "R2 empty list start");

    // Walk A: merge at an odd-count boundary, last period held
    push(0, 0, "R4 push");
    push(33, 1, "R1 list index 33 rejected");
    push(1, 0, "R4 push");
    start_walk(0, "R5 walk A start");
    wait_idle("R5 R7 walk A complete");

    // Walk B: no-merge, merge plus rounding at the same boundary, back-pressure
    clear_list();
    reg_sig(2, 0, 10, 2, 300, 0, "R8 desc");
    reg_sig(3, 0, 20, 3, 300, 0, "R8 desc");
    push(2, 0, "R6 push"); push(3, 0, "R6 push");
    push(2, 0, "R6 push"); push(3, 0, "R6 push");
    bp_on = 1;
    start_walk(0, "R8 walk B start");
    repeat (4) @(negedge clk);
    begin
      @(negedge clk); i_start = 1;
      @(negedge clk); i_start = 0;
      chk(o_reject == 1, "R11 start while busy", o_reject, 1);
      @(negedge clk); i_list_push = 1; i_list_idx = IDX_W'(5);
      @(negedge clk); i_list_push = 0;
      chk(o_reject == 1, "R11 push while busy", o_reject, 1);
    end
    wait_idle("R6 R8 R10 walk B complete");
    bp_on = 0;

    // Walk C: single one-period signal emits nothing
    clear_list();
    reg_sig(5, 1, 30, 1, 0, 0, "R7 desc");
    push(5, 0, "R7 push");
    start_walk(0, "R7 walk C start");
    wait_idle("R7 walk C complete");

    // Walk D: rejected write to 40 left slot 8 intact; negative remainder
    clear_list();
    reg_sig(6, 1, 0, 2, -400, 0, "R8 desc");
    push(6, 0, "R1 push"); push(8, 0, "R1 push");
    start_walk(0, "R1 walk D start");
    wait_idle("R1 R8 walk D complete");

    // R12 clear empties the list
    clear_list();
    start_walk(1, "R12 start after clear");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule